// File: doc/BRIEF.md
# Device Address Translation Walker

This block turns the address of a device's direct memory access request into a host-physical address. Each request carries a 16-bit requester identity, a 57-bit I/O virtual address and a read/write flag. The requester identity picks a translation table in two steps. The bus byte indexes a root table whose base address sits in a configuration register. The device/function byte then indexes that bus's context table, and the context entry gives a page-table root for that one function. From that root the block walks a radix page table of four levels, or five when the wide-address mode is selected. The page offset of the request is appended to the physical page held in the leaf entry.

Table entries are fetched one at a time over a plain request/response memory read port. Only one translation is in progress at a time, and a busy output holds off new requests until the result has been returned. The block blocks a transaction and reports a fault in three cases: an entry on the path is not present, a page-table entry does not grant the access, or the address is too wide for four-level mode. The first fault is kept in a record with the requester, address and direction until software clears it, and any later fault that arrives while the record is occupied only raises an overflow flag.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, busy, resp_valid, flt_valid and flt_overflow are all low.
- R2: The first read of a walk is at root_base + 8*bus, where bus = req_rid[15:8]. The second read is at C + 8*devfn, where devfn = req_rid[7:0] and C is bits 51:12 of the root entry followed by twelve zero bits. Every entry has its present flag in bit 0, and the address of the next table in bits 51:12.
- R3: In four-level mode a mapped read makes exactly 6 reads. The third read is at P + 8*iova[47:39], where P is the table root taken from the context entry. Each following level uses the next lower 9-bit field, down to iova[20:12]. The result is resp_fault=0 and resp_pa = {leaf[51:12], iova[11:0]}.
- R4: With cfg_five_level=1, a mapped walk makes exactly 7 reads, and its third read is at P + 8*iova[56:48].
- R5: A non-present root, context or page-table entry ends the walk at that read with resp_fault=1 and resp_pa=0. No further reads are made.
- R6: In page-table entries, bit 1 grants read and bit 2 grants write. A request that is not granted by any page-table entry on its path faults at that entry, in the same way as a non-present entry. Root and context entries carry no permissions.
- R7: In four-level mode, a request with any of iova[56:48] nonzero faults without making any memory read.
- R8: busy is high from the cycle after a request is accepted until the response is given, and req_valid is ignored while busy is high. Each accepted request produces exactly one response pulse, and only one memory read is outstanding at a time.
- R9: The first fault is stored in the record: flt_valid=1 together with flt_rid, flt_iova and flt_write. A fault that arrives while flt_valid is 1 sets flt_overflow and leaves the record unchanged. A pulse on flt_clear empties the record and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_root_we | input | 1 | Load the root-table base register |
| cfg_root_base | input | 52 | Root-table base (bits 11:0 ignored) |
| cfg_five_level | input | 1 | Select five-level walking, sampled at request acceptance |
| req_valid | input | 1 | Translation request present |
| req_rid | input | 16 | Requester identity: bus[15:8], device[7:3], function[2:0] |
| req_iova | input | 57 | I/O virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| busy | output | 1 | Walk in progress; requests are ignored |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Response is a blocked transaction |
| resp_pa | output | 52 | Translated host-physical address (0 on fault) |
| mem_req_valid | output | 1 | Entry read request (one cycle) |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| flt_clear | input | 1 | Empty the fault record and clear overflow |
| flt_valid | output | 1 | Fault record holds an unread fault |
| flt_rid | output | 16 | Requester of the recorded fault |
| flt_iova | output | 57 | Address of the recorded fault |
| flt_write | output | 1 | Direction of the recorded fault |
| flt_overflow | output | 1 | A fault was dropped while the record was full |

## Verification
The hardest cases to reach from the ports are faults deep inside a walk: a missing entry at an intermediate page-table level, or a missing write grant on an upper-level entry while the leaf grants everything. The bench memory model builds tables on demand. It then requests an address that shares the upper indices of a mapped address but differs in one middle-level index field, and it builds a fresh device's tables with read-only intermediate entries. The number of reads before each fault shows which level stopped the walk. A second request held high across a walk shows that requests are ignored while busy.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
  typedef enum logic [1:0] {PH_ROOT, PH_CTX, PH_PT} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_e;
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_RD      = 1;
  localparam int unsigned BIT_WR      = 2;
endpackage

// File: rtl/dxw_addr_gen.sv
module dxw_addr_gen
  import dxw_pkg::*;
#(
  parameter int unsigned PA_W     = 52,
  parameter int unsigned LVL_BITS = 9,
  parameter int unsigned ENT_LOG2 = 3,
  parameter int unsigned MAX_LVL  = 5,
  parameter int unsigned RID_W    = 16,
  localparam int unsigned PG_SHIFT = LVL_BITS + ENT_LOG2,
  localparam int unsigned IOVA_W   = PG_SHIFT + MAX_LVL * LVL_BITS,
  localparam int unsigned LVL_W    = $clog2(MAX_LVL)
) (
  input  phase_e              phase,
  input  logic [LVL_W-1:0]    level,
  input  logic [PA_W-1:0]     base,
  input  logic [RID_W-1:0]    rid,
  input  logic [IOVA_W-1:0]   iova,
  output logic [PA_W-1:0]     addr
);
  logic [LVL_BITS-1:0] idx [MAX_LVL];
  logic [LVL_BITS-1:0] sel;

  for (genvar g = 0; g < MAX_LVL; g++) begin : g_idx
    assign idx[g] = iova[PG_SHIFT + g*LVL_BITS +: LVL_BITS];
  end

  always_comb begin
    sel = '0;
    case (phase)
      PH_ROOT: sel = LVL_BITS'(rid[RID_W-1:RID_W/2]);
      PH_CTX:  sel = LVL_BITS'(rid[RID_W/2-1:0]);
      default: begin
        for (int k = 0; k < MAX_LVL; k++) begin
          if (level == LVL_W'(k)) sel = idx[k];
        end
      end
    endcase
  end

  assign addr = {base[PA_W-1:PG_SHIFT], sel, {ENT_LOG2{1'b0}}};
endmodule

// File: rtl/dxw_entry_chk.sv
module dxw_entry_chk
  import dxw_pkg::*;
#(
  parameter int unsigned PA_W     = 52,
  parameter int unsigned ENT_W    = 64,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic [ENT_W-1:0] entry,
  input  phase_e           phase,
  input  logic             is_write,
  output logic             ok,
  output logic [PA_W-1:0]  next_base
);
  logic granted;

  always_comb begin
    if (phase != PH_PT) granted = 1'b1;
    else if (is_write)  granted = entry[BIT_WR];
    else                granted = entry[BIT_RD];
  end

  assign ok        = entry[BIT_PRESENT] & granted;
  assign next_base = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
endmodule

// File: rtl/dxw_fault_log.sv
module dxw_fault_log #(
  parameter int unsigned RID_W  = 16,
  parameter int unsigned IOVA_W = 57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [RID_W-1:0]  evt_rid,
  input  logic [IOVA_W-1:0] evt_iova,
  input  logic              evt_write,
  input  logic              clear,
  output logic              flt_valid,
  output logic [RID_W-1:0]  flt_rid,
  output logic [IOVA_W-1:0] flt_iova,
  output logic              flt_write,
  output logic              flt_overflow
);
  logic valid_q, valid_d, ovf_q, ovf_d, store;
  logic [RID_W-1:0]  rid_q;
  logic [IOVA_W-1:0] iova_q;
  logic              wr_q;

  always_comb begin
    store   = evt & (clear | ~valid_q);
    valid_d = clear ? evt : (valid_q | evt);
    ovf_d   = clear ? 1'b0 : (ovf_q | (evt & valid_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rid_q  <= '0;
      iova_q <= '0;
      wr_q   <= 1'b0;
    end else if (store) begin
      rid_q  <= evt_rid;
      iova_q <= evt_iova;
      wr_q   <= evt_write;
    end
  end

  assign flt_valid    = valid_q;
  assign flt_overflow = ovf_q;
  assign flt_rid      = rid_q;
  assign flt_iova     = iova_q;
  assign flt_write    = wr_q;

  // R9: a fault arriving on a full record is dropped, only the flag moves
  assert_overflow_keeps_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && evt && !clear) |=> ($stable(flt_rid) && $stable(flt_iova) && $stable(flt_write) && flt_overflow));

  assert_overflow_with_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_overflow |-> flt_valid);
endmodule

// File: rtl/dxw_walk_ctrl.sv
module dxw_walk_ctrl
  import dxw_pkg::*;
#(
  parameter int unsigned PA_W     = 52,
  parameter int unsigned ENT_W    = 64,
  parameter int unsigned LVL_BITS = 9,
  parameter int unsigned ENT_LOG2 = 3,
  parameter int unsigned MAX_LVL  = 5,
  parameter int unsigned RID_W    = 16,
  localparam int unsigned PG_SHIFT = LVL_BITS + ENT_LOG2,
  localparam int unsigned IOVA_W   = PG_SHIFT + MAX_LVL * LVL_BITS,
  localparam int unsigned VA4_TOP  = PG_SHIFT + (MAX_LVL-1) * LVL_BITS,
  localparam int unsigned LVL_W    = $clog2(MAX_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              five_level,
  input  logic              req_valid,
  input  logic [RID_W-1:0]  req_rid,
  input  logic [IOVA_W-1:0] req_iova,
  input  logic              req_write,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [PA_W-1:0]   resp_pa,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              fault_evt,
  output logic [RID_W-1:0]  cur_rid,
  output logic [IOVA_W-1:0] cur_iova,
  output logic              cur_write
);
  state_e             state_q, state_d;
  phase_e             phase_q, phase_d;
  logic [LVL_W-1:0]   level_q, level_d;
  logic [PA_W-1:0]    base_q, base_d;
  logic               fault_q, fault_d;
  logic [PA_W-1:0]    pa_q, pa_d;
  logic [RID_W-1:0]   rid_q;
  logic [IOVA_W-1:0]  iova_q;
  logic               wr_q, five_q;
  logic               accept, walk_en, range_bad;
  logic               ent_ok;
  logic [PA_W-1:0]    ent_next;

  assign accept    = (state_q == ST_IDLE) & req_valid;
  assign range_bad = ~five_level & (|req_iova[IOVA_W-1:VA4_TOP]);

  dxw_addr_gen #(
    .PA_W(PA_W), .LVL_BITS(LVL_BITS), .ENT_LOG2(ENT_LOG2),
    .MAX_LVL(MAX_LVL), .RID_W(RID_W)
  ) u_addr (
    .phase(phase_q), .level(level_q), .base(base_q),
    .rid(rid_q), .iova(iova_q), .addr(mem_req_addr)
  );

  dxw_entry_chk #(
    .PA_W(PA_W), .ENT_W(ENT_W), .PG_SHIFT(PG_SHIFT)
  ) u_chk (
    .entry(mem_rsp_data), .phase(phase_q), .is_write(wr_q),
    .ok(ent_ok), .next_base(ent_next)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    level_d = level_q;
    base_d  = base_q;
    fault_d = fault_q;
    pa_d    = pa_q;
    walk_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          walk_en = 1'b1;
          phase_d = PH_ROOT;
          level_d = '0;
          base_d  = root_base;
          if (range_bad) begin
            fault_d = 1'b1;
            pa_d    = '0;
            state_d = ST_RESP;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          walk_en = 1'b1;
          if (!ent_ok) begin
            fault_d = 1'b1;
            pa_d    = '0;
            state_d = ST_RESP;
          end else begin
            base_d = ent_next;
            case (phase_q)
              PH_ROOT: begin
                phase_d = PH_CTX;
                state_d = ST_ISSUE;
              end
              PH_CTX: begin
                phase_d = PH_PT;
                level_d = five_q ? LVL_W'(MAX_LVL-1) : LVL_W'(MAX_LVL-2);
                state_d = ST_ISSUE;
              end
              default: begin
                if (level_q == '0) begin
                  fault_d = 1'b0;
                  pa_d    = {ent_next[PA_W-1:PG_SHIFT], iova_q[PG_SHIFT-1:0]};
                  state_d = ST_RESP;
                end else begin
                  level_d = level_q - 1'b1;
                  state_d = ST_ISSUE;
                end
              end
            endcase
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ROOT;
      level_q <= '0;
      base_q  <= '0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else if (walk_en) begin
      phase_q <= phase_d;
      level_q <= level_d;
      base_q  <= base_d;
      fault_q <= fault_d;
      pa_q    <= pa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rid_q  <= '0;
      iova_q <= '0;
      wr_q   <= 1'b0;
      five_q <= 1'b0;
    end else if (accept) begin
      rid_q  <= req_rid;
      iova_q <= req_iova;
      wr_q   <= req_write;
      five_q <= five_level;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign resp_valid    = (state_q == ST_RESP);
  assign resp_fault    = fault_q;
  assign resp_pa       = pa_q;
  assign fault_evt     = resp_valid & fault_q;
  assign cur_rid       = rid_q;
  assign cur_iova      = iova_q;
  assign cur_write     = wr_q;

  // R8: one read outstanding, one response per walk
  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  assert_resp_ends_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !busy);

  // R3: the page offset passes through unchanged
  assert_leaf_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_pa[PG_SHIFT-1:0] == iova_q[PG_SHIFT-1:0]));

  // R7: a four-level translation never succeeds for a wide address
  assert_range_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault && !five_q) |-> (iova_q[IOVA_W-1:VA4_TOP] == '0));
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int unsigned PA_W     = 52,
  parameter int unsigned ENT_W    = 64,
  parameter int unsigned LVL_BITS = 9,
  parameter int unsigned ENT_LOG2 = 3,
  parameter int unsigned MAX_LVL  = 5,
  parameter int unsigned RID_W    = 16,
  localparam int unsigned PG_SHIFT = LVL_BITS + ENT_LOG2,
  localparam int unsigned IOVA_W   = PG_SHIFT + MAX_LVL * LVL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_root_we,
  input  logic [PA_W-1:0]   cfg_root_base,
  input  logic              cfg_five_level,
  input  logic              req_valid,
  input  logic [RID_W-1:0]  req_rid,
  input  logic [IOVA_W-1:0] req_iova,
  input  logic              req_write,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [PA_W-1:0]   resp_pa,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  input  logic              flt_clear,
  output logic              flt_valid,
  output logic [RID_W-1:0]  flt_rid,
  output logic [IOVA_W-1:0] flt_iova,
  output logic              flt_write,
  output logic              flt_overflow
);
  logic [PA_W-1:0]   root_q;
  logic              fault_evt;
  logic [RID_W-1:0]  cur_rid;
  logic [IOVA_W-1:0] cur_iova;
  logic              cur_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           root_q <= '0;
    else if (cfg_root_we) root_q <= {cfg_root_base[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  end

  dxw_walk_ctrl #(
    .PA_W(PA_W), .ENT_W(ENT_W), .LVL_BITS(LVL_BITS),
    .ENT_LOG2(ENT_LOG2), .MAX_LVL(MAX_LVL), .RID_W(RID_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .root_base(root_q), .five_level(cfg_five_level),
    .req_valid(req_valid), .req_rid(req_rid), .req_iova(req_iova), .req_write(req_write),
    .busy(busy), .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fault_evt(fault_evt), .cur_rid(cur_rid), .cur_iova(cur_iova), .cur_write(cur_write)
  );

  dxw_fault_log #(.RID_W(RID_W), .IOVA_W(IOVA_W)) u_flog (
    .clk(clk), .rst_n(rst_n), .evt(fault_evt), .evt_rid(cur_rid),
    .evt_iova(cur_iova), .evt_write(cur_write), .clear(flt_clear),
    .flt_valid(flt_valid), .flt_rid(flt_rid), .flt_iova(flt_iova),
    .flt_write(flt_write), .flt_overflow(flt_overflow)
  );

  // R5: a fault response never carries a translated address
  assert_fault_no_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_pa == '0));
endmodule

// File: tb/tb_dma_xlate_walker.sv
`timescale 1ns/1ps
module tb_dma_xlate_walker;
  localparam logic [51:0] ROOT = 52'h10000;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        cfg_root_we, cfg_five_level, req_valid, req_write, flt_clear;
  logic [51:0] cfg_root_base;
  logic [15:0] req_rid;
  logic [56:0] req_iova;
  logic        busy, resp_valid, resp_fault, mem_req_valid;
  logic [51:0] resp_pa, mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        flt_valid, flt_write, flt_overflow;
  logic [15:0] flt_rid;
  logic [56:0] flt_iova;

  dma_xlate_walker dut (
    .clk(clk), .rst_n(rst_n), .cfg_root_we(cfg_root_we), .cfg_root_base(cfg_root_base),
    .cfg_five_level(cfg_five_level), .req_valid(req_valid), .req_rid(req_rid),
    .req_iova(req_iova), .req_write(req_write), .busy(busy), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_pa(resp_pa), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .flt_clear(flt_clear), .flt_valid(flt_valid), .flt_rid(flt_rid), .flt_iova(flt_iova),
    .flt_write(flt_write), .flt_overflow(flt_overflow)
  );

  // sparse entry memory, one-cycle read latency
  logic [63:0] mem [logic [51:0]];
  logic [51:0] rd_log [16];
  int unsigned nreads = 0;
  int unsigned nresp  = 0;
  logic [51:0] next_free = 52'h100000;

  function automatic logic [63:0] rdval(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid;
    mem_rsp_data  <= rdval(mem_req_addr);
    if (mem_req_valid) begin
      rd_log[nreads[3:0]] <= mem_req_addr;
      nreads <= nreads + 1;
    end
    if (resp_valid) nresp <= nresp + 1;
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] vidx(input logic [56:0] va, input int lvl);
    return va[12 + 9*lvl +: 9];
  endfunction

  function automatic logic [51:0] page(input logic [63:0] e);
    return {e[51:12], 12'h0};
  endfunction

  task automatic alloc(output logic [51:0] p);
    p = next_free;
    next_free = next_free + 52'h1000;
  endtask

  // build tables on demand; intermediate entries get mid_perm, leaf gets leaf_perm
  task automatic build_map(input logic [15:0] rid, input logic [56:0] va, input bit five,
                           input logic [51:0] leaf, input logic [2:0] mid_perm,
                           input logic [2:0] leaf_perm);
    logic [51:0] a, p;
    a = ROOT + {41'h0, rid[15:8], 3'b000};
    if (!mem.exists(a)) begin alloc(p); mem[a] = {12'h0, p} | 64'h1; end
    a = page(mem[a]) + {41'h0, rid[7:0], 3'b000};
    if (!mem.exists(a)) begin alloc(p); mem[a] = {12'h0, p} | 64'h1; end
    for (int l = (five ? 4 : 3); l >= 0; l--) begin
      a = page(mem[a]) + {40'h0, vidx(va, l), 3'b000};
      if (l == 0) mem[a] = {12'h0, leaf} | {61'h0, leaf_perm};
      else if (!mem.exists(a)) begin alloc(p); mem[a] = {12'h0, p} | {61'h0, mid_perm}; end
    end
  endtask

  logic [51:0] r_pa;
  logic        r_fault;
  int unsigned r_reads, r_base;

  task automatic do_req(input logic [15:0] rid, input logic [56:0] va, input bit wr, input bit five);
    int n;
    while (busy) @(negedge clk);
    r_base = nreads;
    req_rid = rid; req_iova = va; req_write = wr; cfg_five_level = five; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
    r_pa = resp_pa; r_fault = resp_fault;
    @(negedge clk);
    r_reads = nreads - r_base;
  endtask

  function automatic logic [51:0] rd_at(input int k);
    return rd_log[(r_base + k) % 16];
  endfunction

  task automatic clear_log();
    flt_clear = 1'b1; @(negedge clk); flt_clear = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy, "R1 busy", 64'(busy), 0);
    check(!resp_valid, "R1 resp_valid", 64'(resp_valid), 0);
    check(!flt_valid, "R1 flt_valid", 64'(flt_valid), 0);
    check(!flt_overflow, "R1 flt_overflow", 64'(flt_overflow), 0);
  endtask

  task automatic t_four_level();
    logic [56:0] va = 57'h0007A5B3C2D1E0F;
    logic [51:0] leaf = 52'hABCDE000, cb, pr;
    build_map(16'h032A, va, 0, leaf, 3'h7, 3'h3);
    do_req(16'h032A, va, 0, 0);
    cb = page(mem[ROOT + 52'h18]);
    pr = page(mem[cb + 52'h150]);
    check(r_reads == 6, "R3 read count", 64'(r_reads), 6);
    check(rd_at(0) == ROOT + 52'h18, "R2 root addr", 64'(rd_at(0)), 64'(ROOT + 52'h18));
    check(rd_at(1) == cb + 52'h150, "R2 ctx addr", 64'(rd_at(1)), 64'(cb + 52'h150));
    check(rd_at(2) == pr + {40'h0, vidx(va,3), 3'b0}, "R3 top pte addr", 64'(rd_at(2)),
          64'(pr + {40'h0, vidx(va,3), 3'b0}));
    check(rd_at(5) == page(mem[rd_at(4)]) + {40'h0, vidx(va,0), 3'b0}, "R3 leaf addr",
          64'(rd_at(5)), 64'(page(mem[rd_at(4)]) + {40'h0, vidx(va,0), 3'b0}));
    check(!r_fault && r_pa == {leaf[51:12], va[11:0]}, "R3 translated pa", 64'(r_pa),
          64'({leaf[51:12], va[11:0]}));
  endtask

  task automatic t_isolation();
    logic [56:0] va = 57'h0007A5B3C2D1E0F;
    logic [51:0] leaf = 52'h5555_5000;
    build_map(16'h0331, va, 0, leaf, 3'h7, 3'h7);
    do_req(16'h0331, va, 1, 0);
    check(!r_fault && r_pa == {leaf[51:12], va[11:0]}, "R2 per-device table", 64'(r_pa),
          64'({leaf[51:12], va[11:0]}));
  endtask

  task automatic t_five_level();
    logic [56:0] va = 57'h12345_6789_ABCDE;
    logic [51:0] leaf = 52'h0F_1234_5000, cb, pr;
    build_map(16'h1F07, va, 1, leaf, 3'h7, 3'h7);
    do_req(16'h1F07, va, 1, 1);
    cb = page(mem[ROOT + {41'h0, 8'h1F, 3'b0}]);
    pr = page(mem[cb + {41'h0, 8'h07, 3'b0}]);
    check(r_reads == 7, "R4 read count", 64'(r_reads), 7);
    check(rd_at(2) == pr + {40'h0, va[56:48], 3'b0}, "R4 top pte addr", 64'(rd_at(2)),
          64'(pr + {40'h0, va[56:48], 3'b0}));
    check(!r_fault && r_pa == {leaf[51:12], va[11:0]}, "R4 translated pa", 64'(r_pa),
          64'({leaf[51:12], va[11:0]}));
  endtask

  task automatic t_nonpresent();
    logic [56:0] va = 57'h0007A5B3C2D1E0F;
    clear_log();
    do_req(16'h7701, va, 0, 0);
    check(r_fault && r_reads == 1 && r_pa == 0, "R5 root missing", {r_fault, 31'h0, r_reads}, {1'b1, 31'h0, 32'd1});
    check(flt_valid && flt_rid == 16'h7701 && flt_iova == va && !flt_write, "R5 record root fault",
          64'(flt_rid), 64'h7701);
    clear_log();
    do_req(16'h0340, va, 0, 0);
    check(r_fault && r_reads == 2, "R5 ctx missing", 64'(r_reads), 2);
    clear_log();
    do_req(16'h032A, va ^ 57'h200000, 1, 0);
    check(r_fault && r_reads == 5, "R5 mid pte missing", 64'(r_reads), 5);
    check(flt_valid && flt_write && flt_iova == (va ^ 57'h200000), "R5 record direction",
          64'(flt_iova), 64'(va ^ 57'h200000));
    clear_log();
  endtask

  task automatic t_perm();
    logic [56:0] va = 57'h0007A5B3C2D1E0F;
    logic [56:0] vb = 57'h0000123456789AB;
    do_req(16'h032A, va, 1, 0);
    check(r_fault && r_reads == 6, "R6 write to read-only leaf", {r_fault, 31'h0, r_reads}, {1'b1, 31'h0, 32'd6});
    build_map(16'h0450, vb, 0, 52'h7777_0000, 3'h3, 3'h7);
    do_req(16'h0450, vb, 0, 0);
    check(!r_fault && r_pa == {40'h77770, vb[11:0]}, "R6 read via read-only path", 64'(r_pa),
          64'({40'h77770, vb[11:0]}));
    do_req(16'h0450, vb, 1, 0);
    check(r_fault && r_reads == 3, "R6 write blocked at upper level", 64'(r_reads), 3);
    clear_log();
  endtask

  task automatic t_range();
    do_req(16'h032A, 57'h0040000_0000_0000 | 57'h0007A5B3C2D1E0F, 0, 0);
    check(r_fault && r_reads == 0, "R7 wide address in four-level", {r_fault, 31'h0, r_reads}, {1'b1, 63'h0});
    clear_log();
  endtask

  task automatic t_busy();
    logic [56:0] va = 57'h0007A5B3C2D1E0F;
    int unsigned n0;
    while (busy) @(negedge clk);
    n0 = nresp; r_base = nreads;
    req_rid = 16'h0331; req_iova = va; req_write = 0; cfg_five_level = 0; req_valid = 1'b1;
    @(negedge clk);
    check(busy, "R8 busy after accept", 64'(busy), 1);
    req_rid = 16'h032A;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    check(resp_pa == {40'h55555, va[11:0]}, "R8 held request ignored", 64'(resp_pa), 64'({40'h55555, va[11:0]}));
    repeat (20) @(negedge clk);
    check(nresp - n0 == 1, "R8 one response", 64'(nresp - n0), 1);
    check(nreads - r_base == 6, "R8 no extra walk", 64'(nreads - r_base), 6);
  endtask

  task automatic t_overflow();
    logic [56:0] va = 57'h0000000ABCDE123;
    clear_log();
    do_req(16'h7701, va, 0, 0);
    do_req(16'h7702, va ^ 57'h1000, 1, 0);
    check(flt_valid && flt_rid == 16'h7701 && !flt_write && flt_iova == va, "R9 first fault kept",
          64'(flt_rid), 64'h7701);
    check(flt_overflow, "R9 overflow set", 64'(flt_overflow), 1);
    clear_log();
    check(!flt_valid && !flt_overflow, "R9 clear", {flt_valid, flt_overflow}, 0);
    do_req(16'h7703, va, 1, 0);
    check(flt_valid && flt_rid == 16'h7703 && flt_write && !flt_overflow, "R9 stored after clear",
          64'(flt_rid), 64'h7703);
  endtask

  initial begin
    rst_n = 1'b0; cfg_root_we = 0; cfg_root_base = 0; cfg_five_level = 0;
    req_valid = 0; req_rid = 0; req_iova = 0; req_write = 0; flt_clear = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_root_base = ROOT | 52'hABC; cfg_root_we = 1'b1;
    @(negedge clk);
    cfg_root_we = 1'b0;
    t_four_level();
    t_isolation();
    t_five_level();
    t_nonpresent();
    t_perm();
    t_range();
    t_busy();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule